// File: doc/BRIEF.md
# Folded Symmetric FIR Decimator

This block filters one channel of signed converter samples and lowers their rate. A sample is taken on every clock edge where `in_valid` is high. Every D accepted samples, the block emits one filtered result, where D is 2, 4 or 8. The impulse response is mirror-symmetric. Because of this, each pair of taps that share a weight is summed before the multiply. Only twelve 11-bit weights are stored, and a small write port loads them. A mode input picks between a 24-tap response and a 23-tap response. In the 23-tap response, the centre tap is weighted alone. The result is scaled, rounded and clamped to 18 bits, two bits wider than the input.

A control state machine has two states, PASS and RUN. In PASS, each accepted sample leaves unfiltered, one for one, shifted up by two bits into the 18-bit format. The transition *enable-rise* moves PASS to RUN and the transition *enable-fall* moves RUN to PASS. The `en` input is registered into the state, so a change on `en` applies to samples accepted from the following cycle on. In RUN, a decimation phase counter decides which accepted sample produces an output. A `sync` input restarts that counter, so several channels can be aligned to emit on the same sample.

Top module: `fir_decim_sym`

## Requirements
- R1: After reset, `out_valid` and `out_data` are 0, the state is PASS, and all twelve stored weights are 0. With reset weights in RUN, every emitted result is 0.
- R2: In PASS, a sample accepted at an edge appears at the next output with `out_valid` high and `out_data` = input × 4, which is the input with two zero LSBs appended. There is one output per accepted sample. `sync` has no effect in PASS.
- R3: `en` acts through the state register. A sample accepted in the same cycle that `en` changes is still handled by the old state. Entering RUN starts the phase counter at 0.
- R4: In RUN, `dec_sel` sets D as follows: 0 gives 2, 1 gives 4, 2 gives 8, and 3 gives 8. The D-th accepted sample of each group emits, with `out_valid` high for one cycle after that edge. Cycles with `in_valid` low do not advance the group.
- R5: Even mode (`odd_mode`=0). Let x0 be the emitting sample and xk the sample accepted k samples before it. The accumulator is the sum over k=0..11 of c[k]·(xk + x(23−k)).
- R6: Odd mode (`odd_mode`=1). The accumulator is the sum over k=0..10 of c[k]·(xk + x(22−k)), plus c[11]·x11. Samples older than x22 do not contribute.
- R7: The output is floor((acc + 64) / 128), which rounds half upward. A single weight of 512 on a lone sample therefore gives the same scale as PASS.
- R8: Results above 131071 are clamped to 131071. Results below −131072 are clamped to −131072.
- R9: A write with `coef_we` high and `coef_addr` from 0 to 11 stores `coef_wdata` as c[addr], in 11-bit two's complement. The new weight is used for results emitted after that edge. Writes to addresses 12 to 15 change no weight.
- R10: In RUN, `sync` high restarts the group. If a sample is accepted in the same cycle, it counts as the first of the new group. If no sample is accepted, the next accepted sample is the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Filter enable; low selects PASS |
| odd_mode | input | 1 | 0 selects 24-tap, 1 selects 23-tap symmetry |
| dec_sel | input | 2 | Decimation select (0:2, 1:4, 2:8, 3:8) |
| sync | input | 1 | Restart of the decimation phase |
| coef_we | input | 1 | Weight write strobe |
| coef_addr | input | 4 | Weight index |
| coef_wdata | input | 11 | Weight value, signed |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Input sample, signed |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 18 | Result, signed |

## Verification
A wrong phase count shows at `out_valid` within one decimation group: the result strobe lands on a sample other than the D-th, or it lands after a `sync` at the wrong spacing. A corrupted delay tap or stored weight does not change strobe timing. It changes the value of the next emitted result, because every result depends on all 23 or 24 of the most recent samples. A rounding or clamping slip shows only on results near a half step or past full scale, so those inputs are driven on purpose.

// File: rtl/fir_pkg.sv
`timescale 1ns/1ps
package fir_pkg;
    typedef enum logic {
        ST_PASS = 1'b0,
        ST_RUN  = 1'b1
    } fmode_t;
endpackage

// File: rtl/fir_coef_bank.sv
`timescale 1ns/1ps
module fir_coef_bank #(
    parameter int NCOEF  = 12,
    parameter int COEF_W = 11,
    parameter int AW     = $clog2(NCOEF)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [AW-1:0]           addr,
    input  logic [COEF_W-1:0]       wdata,
    output logic [NCOEF*COEF_W-1:0] coef_flat
);
    // One register per stored weight; an index past NCOEF-1 matches none.
    for (genvar g = 0; g < NCOEF; g++) begin : g_reg
        logic [COEF_W-1:0] r;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                r <= '0;
            else if (we && addr == AW'(g))
                r <= wdata;
        end
        assign coef_flat[g*COEF_W +: COEF_W] = r;
    end
endmodule

// File: rtl/fir_delay_line.sv
`timescale 1ns/1ps
module fir_delay_line #(
    parameter int NTAP = 24,
    parameter int W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift,
    input  logic [W-1:0]        din,
    output logic [NTAP*W-1:0]   win_flat
);
    // Slot 0 is the sample at the port; slots 1..NTAP-1 are stored history.
    assign win_flat[0 +: W] = din;
    for (genvar g = 0; g < NTAP-1; g++) begin : g_tap
        logic [W-1:0] r;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                r <= '0;
            else if (shift)
                r <= win_flat[g*W +: W];
        end
        assign win_flat[(g+1)*W +: W] = r;
    end
endmodule

// File: rtl/fir_fold_mac.sv
`timescale 1ns/1ps
module fir_fold_mac #(
    parameter int NCOEF  = 12,
    parameter int IN_W   = 16,
    parameter int COEF_W = 11,
    parameter int OUT_W  = 18,
    parameter int SHIFT  = 7
) (
    input  logic [2*NCOEF*IN_W-1:0] win_flat,
    input  logic [NCOEF*COEF_W-1:0] coef_flat,
    input  logic                    odd_mode,
    output logic [OUT_W-1:0]        y
);
    localparam int NTAP   = 2*NCOEF;
    localparam int PRE_W  = IN_W + 1;
    localparam int PROD_W = PRE_W + COEF_W;
    localparam int ACC_W  = PROD_W + $clog2(NCOEF) + 1;
    localparam logic signed [ACC_W:0] RND  = {{(ACC_W+1-SHIFT){1'b0}}, 1'b1, {(SHIFT-1){1'b0}}};
    localparam logic signed [ACC_W:0] OMAX = {{(ACC_W+2-OUT_W){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [ACC_W:0] OMIN = {{(ACC_W+2-OUT_W){1'b1}}, {(OUT_W-1){1'b0}}};

    logic signed [PROD_W-1:0] prod [NCOEF];

    for (genvar k = 0; k < NCOEF; k++) begin : g_fold
        logic signed [IN_W-1:0]   near, far_e, far_o;
        logic signed [PRE_W-1:0]  pre;
        logic signed [COEF_W-1:0] c;
        assign near  = $signed(win_flat[k*IN_W +: IN_W]);
        assign far_e = $signed(win_flat[(NTAP-1-k)*IN_W +: IN_W]);
        assign far_o = $signed(win_flat[(NTAP-2-k)*IN_W +: IN_W]);
        assign c     = $signed(coef_flat[k*COEF_W +: COEF_W]);
        if (k == NCOEF-1) begin : g_ctr
            // Odd length: centre sample stands alone.
            assign pre = odd_mode ? PRE_W'(near) : PRE_W'(near) + PRE_W'(far_e);
        end else begin : g_pair
            assign pre = PRE_W'(near) + (odd_mode ? PRE_W'(far_o) : PRE_W'(far_e));
        end
        assign prod[k] = pre * c;
    end

    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W:0]   scaled;

    always_comb begin
        acc = '0;
        for (int k = 0; k < NCOEF; k++)
            acc = acc + ACC_W'(prod[k]);
        scaled = ((ACC_W+1)'(acc) + RND) >>> SHIFT;
        if (scaled > OMAX)
            y = OMAX[OUT_W-1:0];
        else if (scaled < OMIN)
            y = OMIN[OUT_W-1:0];
        else
            y = scaled[OUT_W-1:0];
    end
endmodule

// File: rtl/fir_decim_sym.sv
`timescale 1ns/1ps
module fir_decim_sym #(
    parameter int NCOEF   = 12,
    parameter int IN_W    = 16,
    parameter int COEF_W  = 11,
    parameter int OUT_W   = 18,
    parameter int SHIFT   = 7,
    parameter int MAX_DEC = 8,
    parameter int AW      = $clog2(NCOEF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              odd_mode,
    input  logic [1:0]        dec_sel,
    input  logic              sync,
    input  logic              coef_we,
    input  logic [AW-1:0]     coef_addr,
    input  logic [COEF_W-1:0] coef_wdata,
    input  logic              in_valid,
    input  logic [IN_W-1:0]   in_data,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_data
);
    import fir_pkg::*;

    localparam int NTAP = 2*NCOEF;
    localparam int PH_W = $clog2(MAX_DEC);
    localparam int EXT  = OUT_W - IN_W;

    fmode_t st, st_nxt;
    logic [PH_W-1:0]          phase, phase_now, last_idx;
    logic                     last;
    logic [NCOEF*COEF_W-1:0]  coef_flat;
    logic [NTAP*IN_W-1:0]     win_flat;
    logic [OUT_W-1:0]         y;

    fir_coef_bank #(.NCOEF(NCOEF), .COEF_W(COEF_W), .AW(AW)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(coef_we), .addr(coef_addr),
        .wdata(coef_wdata), .coef_flat(coef_flat)
    );

    fir_delay_line #(.NTAP(NTAP), .W(IN_W)) u_line (
        .clk(clk), .rst_n(rst_n), .shift(in_valid), .din(in_data),
        .win_flat(win_flat)
    );

    fir_fold_mac #(.NCOEF(NCOEF), .IN_W(IN_W), .COEF_W(COEF_W),
                   .OUT_W(OUT_W), .SHIFT(SHIFT)) u_mac (
        .win_flat(win_flat), .coef_flat(coef_flat), .odd_mode(odd_mode), .y(y)
    );

    // Group length minus one: 1, 3, 7, 7.
    always_comb begin
        unique case (dec_sel)
            2'd0:    last_idx = PH_W'(1);
            2'd1:    last_idx = PH_W'(3);
            default: last_idx = PH_W'(MAX_DEC-1);
        endcase
        phase_now = sync ? '0 : phase;
        last      = (phase_now == last_idx);
    end

    // Next-state: enable-rise and enable-fall.
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_PASS: if (en)  st_nxt = ST_RUN;
            ST_RUN:  if (!en) st_nxt = ST_PASS;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_PASS;
        else        st <= st_nxt;
    end

    // Output and phase process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase     <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            unique case (st)
                ST_PASS: begin
                    phase     <= '0;
                    out_valid <= in_valid;
                    if (in_valid)
                        out_data <= {in_data, {EXT{1'b0}}};
                end
                ST_RUN: begin
                    if (in_valid) begin
                        out_valid <= last;
                        phase     <= last ? '0 : phase_now + PH_W'(1);
                        if (last)
                            out_data <= y;
                    end else begin
                        out_valid <= 1'b0;
                        phase     <= phase_now;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/fir_decim_chk.sv
`timescale 1ns/1ps
module fir_decim_chk #(
    parameter int NCOEF  = 12,
    parameter int IN_W   = 16,
    parameter int COEF_W = 11,
    parameter int OUT_W  = 18,
    parameter int PH_W   = 3,
    parameter int AW     = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    sync,
    input logic                    in_valid,
    input logic [IN_W-1:0]         in_data,
    input logic                    coef_we,
    input logic [AW-1:0]           coef_addr,
    input logic [COEF_W-1:0]       coef_wdata,
    input logic                    out_valid,
    input logic [OUT_W-1:0]        out_data,
    input fir_pkg::fmode_t         st,
    input logic [PH_W-1:0]         phase,
    input logic [NCOEF*COEF_W-1:0] coef_flat
);
    import fir_pkg::*;
    localparam int EXT = OUT_W - IN_W;

    a_r2_bypass_echo: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PASS && in_valid) |=> (out_valid && out_data == {$past(in_data), {EXT{1'b0}}}));

    a_r3_pass_holds_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PASS && $past(st) == ST_PASS) |-> (phase == '0));

    a_r4_output_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    a_r10_sync_clears_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (sync && !in_valid) |=> (phase == '0));

    for (genvar g = 0; g < NCOEF; g++) begin : g_w
        a_r9_coef_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (coef_we && coef_addr == AW'(g)) |=> (coef_flat[g*COEF_W +: COEF_W] == $past(coef_wdata)));
    end
endmodule

bind fir_decim_sym fir_decim_chk #(
    .NCOEF(NCOEF), .IN_W(IN_W), .COEF_W(COEF_W), .OUT_W(OUT_W),
    .PH_W($clog2(MAX_DEC)), .AW(AW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sync(sync), .in_valid(in_valid), .in_data(in_data),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_wdata(coef_wdata),
    .out_valid(out_valid), .out_data(out_data), .st(st), .phase(phase),
    .coef_flat(coef_flat)
);

// File: tb/sim_fir_decim_sym.sv
`timescale 1ns/1ps
module sim_fir_decim_sym;
    logic        clk = 0, rst_n = 0, en = 0, odd_mode = 0, sync = 0;
    logic        coef_we = 0, in_valid = 0;
    logic [1:0]  dec_sel = 0;
    logic [3:0]  coef_addr = 0;
    logic [10:0] coef_wdata = 0;
    logic [15:0] in_data = 0;
    logic        out_valid;
    logic [17:0] out_data;

    int  checks = 0, fails = 0;
    bit  done = 0;
    int  h [24];
    int  mc [12];
    bit  m_run = 0;
    int  mphase = 0;

    fir_decim_sym u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .odd_mode(odd_mode), .dec_sel(dec_sel),
        .sync(sync), .coef_we(coef_we), .coef_addr(coef_addr), .coef_wdata(coef_wdata),
        .in_valid(in_valid), .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int mlen();
        return (dec_sel == 2'd0) ? 2 : (dec_sel == 2'd1) ? 4 : 8;
    endfunction

    // Reference arithmetic written from R5..R8.
    function automatic longint model_out();
        longint acc = 0, r;
        if (!odd_mode) begin
            for (int k = 0; k < 12; k++) acc += longint'(mc[k]) * (h[k] + h[23-k]);
        end else begin
            for (int k = 0; k < 11; k++) acc += longint'(mc[k]) * (h[k] + h[22-k]);
            acc += longint'(mc[11]) * h[11];
        end
        r = (acc + 64) >>> 7;
        if (r > 131071)  r = 131071;
        if (r < -131072) r = -131072;
        return r;
    endfunction

    // Entered and left at a falling edge.
    task automatic push(input int x, input bit s, input string req);
        bit ev; longint ed = 0; int ph;
        in_valid = 1; in_data = 16'(x); sync = s;
        @(posedge clk);
        for (int k = 23; k > 0; k--) h[k] = h[k-1];
        h[0] = x;
        if (!m_run) begin
            ev = 1; ed = longint'(x) * 4;
        end else begin
            ph = s ? 0 : mphase;
            ev = (ph == mlen() - 1);
            mphase = ev ? 0 : ph + 1;
            if (ev) ed = model_out();
        end
        @(negedge clk);
        in_valid = 0; sync = 0;
        chk(out_valid == ev, req, out_valid, ev);
        if (ev) chk(longint'($signed(out_data)) == ed, req, $signed(out_data), ed);
    endtask

    task automatic idle(input bit s);
        in_valid = 0; sync = s;
        @(posedge clk);
        if (s && m_run) mphase = 0;
        @(negedge clk);
        sync = 0;
        chk(out_valid == 0, "R4 no input no output", out_valid, 0);
    endtask

    task automatic set_en(input bit b);
        en = b;
        idle(0);
        m_run = b; mphase = 0;
    endtask

    task automatic wr_coef(input int a, input int v);
        coef_we = 1; coef_addr = 4'(a); coef_wdata = 11'(v);
        @(posedge clk);
        @(negedge clk);
        coef_we = 0;
        if (a < 12) mc[a] = v;
    endtask

    task automatic t_reset();
        chk(out_valid == 0, "R1 reset valid", out_valid, 0);
        chk(out_data == 0, "R1 reset data", out_data, 0);
        set_en(1);
        dec_sel = 0;
        push(30000, 1, "R1 zero weights");
        push(-20000, 0, "R1 zero weights");
        chk(out_data == 0, "R1 zero weights result", $signed(out_data), 0);
        set_en(0);
    endtask

    task automatic t_bypass();
        push(16'sh1234, 0, "R2 pass");
        push(-5, 1, "R2 pass sync ignored");
        push(32767, 0, "R2 pass max");
        push(-32768, 0, "R2 pass min");
        idle(0);
        push(7, 0, "R2 pass after gap");
    endtask

    task automatic t_mode();
        // R3: en changes with a sample in the same cycle; old state applies.
        en = 1;
        push(1000, 0, "R3 lag on enable");
        m_run = 1; mphase = 0;
        dec_sel = 0;
        push(11, 0, "R3 run phase starts at 0");
        push(12, 0, "R3 run phase starts at 0");
        en = 0;
        push(13, 0, "R3 lag on disable");
        m_run = 0;
        push(14, 0, "R3 back in pass");
    endtask

    task automatic t_weights();
        int cv [12] = '{5, -12, -1024, -60, 110, -190, 300, -450, 620, -800, 950, 1023};
        for (int k = 0; k < 12; k++) wr_coef(k, cv[k]);
        // R9: addresses 12..15 must not alias onto stored weights.
        for (int a = 12; a < 16; a++) wr_coef(a, 777);
        set_en(1);
        odd_mode = 0; dec_sel = 0;
        push(0, 1, "R9 align");
        for (int i = 0; i < 40; i++) push(((i * 7919) % 65536) - 32768, 0, "R5 even stream");
    endtask

    task automatic t_dec();
        for (int sel = 1; sel < 4; sel++) begin
            dec_sel = 2'(sel);
            push(100, 1, "R4 decimation");
            for (int i = 0; i < 20; i++) begin
                push(((i * 4099) % 50000) - 25000, 0, "R4 decimation");
                if (i % 5 == 2) idle(0);
            end
        end
    endtask

    task automatic t_odd();
        odd_mode = 1; dec_sel = 0;
        push(0, 1, "R6 align");
        for (int i = 0; i < 40; i++) push(((i * 6151) % 60000) - 30000, 0, "R6 odd stream");
        odd_mode = 0;
    endtask

    task automatic t_round();
        for (int k = 0; k < 12; k++) wr_coef(k, 0);
        wr_coef(0, 1);
        dec_sel = 0;
        push(0, 1, "R7 flush");
        for (int i = 0; i < 25; i++) push(0, 0, "R7 flush");
        push(0, 1, "R7"); push(64, 0, "R7 half step up");       // (64+64)>>7 = 1
        push(0, 0, "R7"); push(32, 0, "R7 below half");          // 0
        push(0, 0, "R7"); push(-64, 0, "R7 negative half");      // 0
        push(0, 0, "R7"); push(-65, 0, "R7 past negative half"); // -1
        chk($signed(out_data) == -1, "R7 explicit -65", $signed(out_data), -1);
        wr_coef(0, 512);
        push(0, 0, "R7"); push(-3000, 0, "R7 unity scale");      // -12000
        chk($signed(out_data) == -12000, "R7 unity scale explicit", $signed(out_data), -12000);
    endtask

    task automatic t_sat();
        for (int k = 0; k < 12; k++) wr_coef(k, 1023);
        dec_sel = 0;
        push(32767, 1, "R8 sat");
        for (int i = 0; i < 25; i++) push(32767, 0, "R8 sat high");
        chk(out_data == 18'h1FFFF, "R8 clamp high", $signed(out_data), 131071);
        for (int i = 0; i < 26; i++) push(-32768, 0, "R8 sat low");
        chk(out_data == 18'h20000, "R8 clamp low", $signed(out_data), -131072);
    endtask

    task automatic t_sync();
        wr_coef(0, 200); wr_coef(5, -300); wr_coef(11, 100);
        dec_sel = 1;
        push(10, 0, "R10 pre");
        push(20, 0, "R10 pre");
        push(30, 1, "R10 sync with sample");
        push(40, 0, "R10");
        push(50, 0, "R10");
        push(60, 0, "R10 fourth emits");
        chk(out_valid == 1, "R10 emit after sync+3", out_valid, 1);
        push(70, 0, "R10");
        idle(1);
        push(80, 0, "R10 after idle sync");
        push(90, 0, "R10");
        push(95, 0, "R10");
        push(99, 0, "R10 fourth emits");
        chk(out_valid == 1, "R10 emit after idle sync", out_valid, 1);
    endtask

    initial begin
        for (int k = 0; k < 24; k++) h[k] = 0;
        for (int k = 0; k < 12; k++) mc[k] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_bypass();
        t_mode();
        t_weights();
        t_dec();
        t_odd();
        t_round();
        t_sat();
        t_sync();
        set_en(0);
        push(-1234, 0, "R2 pass at end");
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule